// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block sits between a UART's status logic and its CPU bus. It gathers five interrupt sources: receiver line status, receive data ready, receive timeout, transmitter holding register empty and modem status. Each source has its own enable bit. The block drives one interrupt output that is high while any enabled source is pending. It also keeps an 8-bit identification value. The low nibble of that value names the most urgent enabled pending source.

The CPU reads the identification value with a one-cycle read strobe. The value is snapshotted into a register at that strobe and held until the next read. A read acknowledges only the source that it reports. Of the five sources, only the transmitter-empty one holds state inside this block. It latches on a rising edge of the holding-register-empty condition and is cleared by a read that reports it or by a write to the holding register. The other four sources are levels owned by their status logic. This block only ranks and encodes them, so a lower-ranked source shows up on a later read once the higher ones have gone away.

The upper two bits of the value show whether the FIFOs are in use, and bits 5:4 are always zero.

Top module: `irqIdentifier`

## Requirements
- R1: In reset and at its release, `idData` is 8'h01 and `irqOut` is 0.
- R2: The low nibble of a snapshot reads 4'b0001 when no enabled source is pending. When any enabled source is pending, bit 0 of the snapshot is 0.
- R3: When several enabled sources are pending, exactly one is reported. From highest to lowest, the ranking and codes are: line status 4'b0110, receive data ready 4'b0100, receive timeout 4'b1100, transmitter empty 4'b0010, modem status 4'b0000. When data ready and timeout are both pending, data ready is reported.
- R4: `srcEnable` bit 0 gates line status, bit 1 gates data ready, bit 2 gates timeout, bit 3 gates transmitter empty and bit 4 gates modem status. A disabled source affects neither `irqOut` nor the code.
- R5: `irqOut` is high exactly when at least one enabled source is pending. It follows the level inputs in the same cycle and follows the latched transmitter-empty state one cycle after it changes.
- R6: The transmitter-empty source becomes pending on the clock edge where `txEmpty` is 1 and was 0 at the previous edge. Holding `txEmpty` high does not re-arm it after it has been cleared.
- R7: A read whose snapshot reports transmitter empty clears that source. A read that reports any other source leaves it pending.
- R8: A cycle with `thrWrite` high clears a pending transmitter-empty source.
- R9: If a rising edge of `txEmpty` falls on the same clock as a clearing read or a `thrWrite`, the source ends up pending.
- R10: Bits 5:4 of `idData` are always 0. Bits 7:6 read 2'b11 if `fifoOn` was 1 at the read strobe and 2'b00 otherwise.
- R11: `idData` is loaded only at a clock edge where `idRead` is high, from the state before that edge. It holds its value between reads.
- R12: Reads never clear line status, data ready, timeout or modem status. While one of these stays asserted, each re-read reports it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEnable | input | 5 | Per-source enables (bit map in R4) |
| fifoOn | input | 1 | FIFOs in use, reflected in bits 7:6 |
| lineStatusIrq | input | 1 | Receiver line status level |
| rxReadyIrq | input | 1 | Receive data ready level |
| rxTimeoutIrq | input | 1 | Receive timeout level |
| modemIrq | input | 1 | Modem status level |
| txEmpty | input | 1 | Transmit holding register empty level |
| thrWrite | input | 1 | Write strobe to the transmit holding register |
| idRead | input | 1 | Identification read strobe |
| idData | output | 8 | Identification snapshot |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench walks all five sources down the ranking one read at a time. A design with a wrong order or a wrong code would report the wrong nibble on some read, and a design whose reads cleared level sources would drop a source that is still asserted. It holds `txEmpty` high after a clear to show that a level-triggered latch would fire again. It lines up a new empty edge with a clearing read, and with a holding-register write, to catch a design where the clear wins and the new event is lost. It also checks reads that report other sources while transmitter empty is pending, which catches a design that clears too widely. Random stimulus then mixes enables, FIFO mode and reads while a cycle-level model checks both outputs on every clock.

// File: rtl/irqIdPkg.sv
package irqIdPkg;

  localparam int NUM_SRC = 5;
  localparam int CODE_W  = 4;
  localparam int ID_W    = 8;

  // source index doubles as priority rank (0 = most urgent)
  localparam int SRC_LINE  = 0;
  localparam int SRC_RXRDY = 1;
  localparam int SRC_RXTMO = 2;
  localparam int SRC_TXEMP = 3;
  localparam int SRC_MODEM = 4;

  localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

  typedef struct packed {
    logic capture;  // snapshot the identification value this edge
    logic txAck;    // this read acknowledges the transmitter-empty source
  } ctrlStrobe_t;

  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    case (idx)
      SRC_LINE:  srcCode = 4'b0110;
      SRC_RXRDY: srcCode = 4'b0100;
      SRC_RXTMO: srcCode = 4'b1100;
      SRC_TXEMP: srcCode = 4'b0010;
      default:   srcCode = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/irqIdCtrl.sv
module irqIdCtrl
  import irqIdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txEmpty,
  input  logic        thrWrite,
  input  logic        idRead,
  input  logic        txReported,
  output ctrlStrobe_t strobe,
  output logic        txPend
);

  logic txPrev;
  logic txRise;
  logic readAck;
  logic clearReq;

  assign txRise   = txEmpty & ~txPrev;
  assign readAck  = idRead & txReported;
  assign clearReq = readAck | thrWrite;

  always_comb begin
    strobe.capture = idRead;
    strobe.txAck   = readAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPrev <= 1'b0;
      txPend <= 1'b0;
    end else begin
      txPrev <= txEmpty;
      if (txRise)        txPend <= 1'b1;
      else if (clearReq) txPend <= 1'b0;
    end
  end

  AST_TX_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(readAck) && !$past(txRise)) |-> !txPend); // R7

  AST_TX_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(thrWrite) && !$past(txRise)) |-> !txPend); // R8

  AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(txRise) |-> txPend); // R9

  AST_TX_NO_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(txPend) && $past(txPrev) && $past(txEmpty)) |-> !txPend); // R6

endmodule

// File: rtl/irqIdData.sv
module irqIdData
  import irqIdPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] pendRaw,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               fifoOn,
  output logic [NUM_SRC-1:0] reportSel,
  output logic [ID_W-1:0]    idData,
  output logic               irqOut
);

  localparam int RSV_W  = ID_W - CODE_W - 2;
  localparam logic [ID_W-1:0] ID_RESET = {2'b00, {RSV_W{1'b0}}, CODE_NONE};

  logic [NUM_SRC-1:0] pendGated;
  logic [CODE_W-1:0]  liveCode;
  logic               taken;

  assign pendGated = pendRaw & srcEnable;
  assign irqOut    = |pendGated;

  always_comb begin
    taken = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      reportSel[i] = pendGated[i] & ~taken;
      taken        = taken | pendGated[i];
    end
  end

  always_comb begin
    liveCode = CODE_NONE;
    if (|pendGated) begin
      liveCode = '0;
      for (int i = 0; i < NUM_SRC; i++)
        if (reportSel[i]) liveCode = liveCode | srcCode(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               idData <= ID_RESET;
    else if (strobe.capture) idData <= {{2{fifoOn}}, {RSV_W{1'b0}}, liveCode};
  end

  AST_ONE_REPORTED: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reportSel) && ((reportSel != '0) == irqOut)); // R3

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    idData[5:4] == 2'b00); // R10

  AST_FIFO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture) |-> idData[7:6] == {2{$past(fifoOn)}}); // R10

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capture) |-> $stable(idData)); // R11

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.capture) && !$past(irqOut)) |-> idData[3:0] == CODE_NONE); // R2

  AST_PEND_BIT0: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.capture) && $past(irqOut)) |-> !idData[0]); // R2

  AST_TX_ACK_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txAck |-> reportSel[SRC_TXEMP]); // R7

endmodule

// File: rtl/irqIdentifier.sv
module irqIdentifier
  import irqIdPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcEnable,
  input  logic                fifoOn,
  input  logic                lineStatusIrq,
  input  logic                rxReadyIrq,
  input  logic                rxTimeoutIrq,
  input  logic                modemIrq,
  input  logic                txEmpty,
  input  logic                thrWrite,
  input  logic                idRead,
  output logic [ID_W-1:0]     idData,
  output logic                irqOut
);

  ctrlStrobe_t        strobe;
  logic               txPend;
  logic [NUM_SRC-1:0] pendRaw;
  logic [NUM_SRC-1:0] reportSel;

  always_comb begin
    pendRaw            = '0;
    pendRaw[SRC_LINE]  = lineStatusIrq;
    pendRaw[SRC_RXRDY] = rxReadyIrq;
    pendRaw[SRC_RXTMO] = rxTimeoutIrq;
    pendRaw[SRC_TXEMP] = txPend;
    pendRaw[SRC_MODEM] = modemIrq;
  end

  irqIdCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEmpty    (txEmpty),
    .thrWrite   (thrWrite),
    .idRead     (idRead),
    .txReported (reportSel[SRC_TXEMP]),
    .strobe     (strobe),
    .txPend     (txPend)
  );

  irqIdData uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pendRaw   (pendRaw),
    .srcEnable (srcEnable),
    .fifoOn    (fifoOn),
    .reportSel (reportSel),
    .idData    (idData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/sim_irqIdentifier.sv
module sim_irqIdentifier;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] srcEnable = '0;
  logic       fifoOn = 1'b0;
  logic       lineStatusIrq = 1'b0;
  logic       rxReadyIrq = 1'b0;
  logic       rxTimeoutIrq = 1'b0;
  logic       modemIrq = 1'b0;
  logic       txEmpty = 1'b0;
  logic       thrWrite = 1'b0;
  logic       idRead = 1'b0;
  logic [7:0] idData;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit       mTx = 1'b0;
  bit       mPrev = 1'b0;
  bit [7:0] mId = 8'h01;

  always #5 clk = ~clk;

  irqIdentifier u0 (
    .clk(clk), .rstN(rstN), .srcEnable(srcEnable), .fifoOn(fifoOn),
    .lineStatusIrq(lineStatusIrq), .rxReadyIrq(rxReadyIrq),
    .rxTimeoutIrq(rxTimeoutIrq), .modemIrq(modemIrq), .txEmpty(txEmpty),
    .thrWrite(thrWrite), .idRead(idRead), .idData(idData), .irqOut(irqOut)
  );

  function automatic bit [3:0] modelCode();
    if (srcEnable[0] && lineStatusIrq) return 4'b0110;
    if (srcEnable[1] && rxReadyIrq)    return 4'b0100;
    if (srcEnable[2] && rxTimeoutIrq)  return 4'b1100;
    if (srcEnable[3] && mTx)           return 4'b0010;
    if (srcEnable[4] && modemIrq)      return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic bit modelIrq();
    return (srcEnable[0] && lineStatusIrq) || (srcEnable[1] && rxReadyIrq) ||
           (srcEnable[2] && rxTimeoutIrq) || (srcEnable[3] && mTx) ||
           (srcEnable[4] && modemIrq);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit [3:0] c;
    bit rise;
    c = modelCode();
    rise = txEmpty && !mPrev;
    if (idRead) mId = {fifoOn ? 2'b11 : 2'b00, 2'b00, c};
    if (rise) mTx = 1'b1;
    else if ((idRead && c == 4'b0010) || thrWrite) mTx = 1'b0;
    mPrev = txEmpty;
  endtask

  // called at a negedge after inputs are set: compare, clock, update model
  task automatic tick(input string tag);
    #2;
    check(tag, idData, mId);
    check(tag, {7'd0, irqOut}, {7'd0, modelIrq()});
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic readOnce(input string tag);
    idRead = 1'b1;
    tick(tag);
    idRead = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", idData, 8'h01);
    check("R1", {7'd0, irqOut}, 8'h00);
    rstN = 1'b1;
    tick("R1");

    srcEnable = 5'b11111;
    // R2: idle read, then single pending source
    readOnce("R2");
    lineStatusIrq = 1'b1;
    tick("R2");
    readOnce("R2");
    tick("R2");

    // R3: all pending, walk down the ranking
    rxReadyIrq = 1'b1; rxTimeoutIrq = 1'b1; modemIrq = 1'b1; txEmpty = 1'b1;
    tick("R3");
    readOnce("R3");
    readOnce("R12");
    lineStatusIrq = 1'b0;
    readOnce("R3");
    rxReadyIrq = 1'b0;
    readOnce("R3");
    // R7: read reporting timeout leaves tx pending
    readOnce("R7");
    rxTimeoutIrq = 1'b0;
    readOnce("R7");
    // R6: tx level still high, must not re-arm
    tick("R6");
    readOnce("R6");
    readOnce("R12");
    modemIrq = 1'b0;
    readOnce("R2");

    // R4: disabled sources ignored
    srcEnable = 5'b00000;
    lineStatusIrq = 1'b1; modemIrq = 1'b1;
    tick("R4");
    readOnce("R4");
    srcEnable = 5'b10000;
    readOnce("R4");
    srcEnable = 5'b11110;
    readOnce("R4");
    lineStatusIrq = 1'b0; modemIrq = 1'b0;
    srcEnable = 5'b11111;

    // R8: write clears tx pending
    txEmpty = 1'b0; tick("R8");
    txEmpty = 1'b1; tick("R8");
    tick("R5");
    thrWrite = 1'b1; tick("R8"); thrWrite = 1'b0;
    tick("R8");
    readOnce("R8");

    // R9: new edge coinciding with clearing read, and with write
    txEmpty = 1'b0; tick("R9");
    txEmpty = 1'b1; tick("R9");
    txEmpty = 1'b0; tick("R9");
    txEmpty = 1'b1; idRead = 1'b1; tick("R9"); idRead = 1'b0;
    tick("R9");
    txEmpty = 1'b0; tick("R9");
    txEmpty = 1'b1; thrWrite = 1'b1; tick("R9"); thrWrite = 1'b0;
    readOnce("R9");
    readOnce("R9");

    // R10: FIFO flags
    fifoOn = 1'b1;
    readOnce("R10");
    modemIrq = 1'b1;
    readOnce("R10");
    fifoOn = 1'b0;
    readOnce("R10");
    modemIrq = 1'b0;

    // R11: snapshot holds while sources change without a read
    rxTimeoutIrq = 1'b1; tick("R11");
    rxReadyIrq = 1'b1; tick("R11");
    readOnce("R11");
    rxReadyIrq = 1'b0; rxTimeoutIrq = 1'b0;
    tick("R11"); tick("R11");

    // R5: random mix
    for (int i = 0; i < 4000; i++) begin
      srcEnable     = 5'($urandom());
      fifoOn        = 1'($urandom());
      lineStatusIrq = ($urandom_range(0, 5) == 0);
      rxReadyIrq    = ($urandom_range(0, 3) == 0);
      rxTimeoutIrq  = ($urandom_range(0, 3) == 0);
      modemIrq      = ($urandom_range(0, 2) == 0);
      txEmpty       = ($urandom_range(0, 2) != 0);
      thrWrite      = ($urandom_range(0, 7) == 0);
      idRead        = ($urandom_range(0, 2) == 0);
      tick("R5");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule